// File: doc/BRIEF.md
# Trimmed Seconds Divider with Test Pin

This block turns a 32,768 Hz oscillator enable into a one-second tick for a timekeeping counter chain. It also gives a 512 Hz square wave for frequency measurement, and it drives one output pin that shows either that square wave or a fixed level chosen by software. The oscillator enable is a single-cycle pulse in the system clock domain. It arrives at the crystal rate, and every state change in the block is gated by it.

Crystal error is trimmed digitally, once per window of several seconds. A 5-bit magnitude and a direction bit come from a control byte. At the start of each window the magnitude is captured. During the first second of the window that many oscillator pulses are either swallowed, which lengthens the second, or counted double, which shortens it. The result is a long-term rate correction without changing the oscillator.

Top module: `cal_divider`

## Requirements
- R1: While `rstN` is low and at the first sampling point after it, `tickOut` and `sqOut` are 0, and no trim is applied in the first window after reset. All seconds of that window last exactly 2^DIV_BITS enables.
- R2: With no trim pending, each second lasts exactly 2^DIV_BITS `oscEn` pulses, and the tick goes high for one system clock after the pulse that completes it.
- R3: Cycles with `oscEn` low change no state. The second length counts enables, not system clocks.
- R4: `sqOut` equals bit TAP_BIT of the divider position. Its period is 2^(TAP_BIT+1) enables, which gives 512 Hz at the default values.
- R5: `pinOut` follows `sqOut` when `ctrlByte[6]` is 1, and it equals `ctrlByte[7]` when `ctrlByte[6]` is 0.
- R6: A trim window is 2^WIN_BITS seconds long. The magnitude `ctrlByte[4:0]` is captured on the tick that ends the last second of a window, and it is applied within the first second of the next window.
- R7: With `ctrlByte[5]` = 0 (slow down), the trimmed second lasts 2^DIV_BITS + magnitude enables.
- R8: With `ctrlByte[5]` = 1 (speed up), the trimmed second lasts 2^DIV_BITS − magnitude enables.
- R9: A magnitude of 0 leaves every second exactly 2^DIV_BITS enables long, whatever the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One-cycle pulse at the oscillator rate |
| ctrlByte | input | 8 | [7] static pin level, [6] test tone select, [5] trim direction (1 = faster), [4:0] trim magnitude |
| tickOut | output | 1 | One-cycle pulse per second |
| sqOut | output | 1 | Test square wave (512 Hz at defaults) |
| pinOut | output | 1 | Shared output pin value |

## Verification
The bench builds the block with DIV_BITS = 8, TAP_BIT = 2 and WIN_BITS = 2. A second is then 256 enables and a window is four seconds, so ten seconds in each run cover two trimmed seconds and eight plain ones. At these values the bench can sweep both directions with magnitudes from 0 up to the 31 maximum, and it can follow the square wave enable by enable against the arithmetic divider position. The enable arrives every other clock, so gating by `oscEn` is exercised throughout.

// File: rtl/cal_div_pkg.sv
package cal_div_pkg;
  localparam int CAL_W = 5;

  typedef struct packed {
    logic hold;   // swallow this oscillator pulse
    logic dbl;    // count this oscillator pulse twice
  } stepCtl_t;
endpackage

// File: rtl/cal_div_ctrl.sv
module cal_div_ctrl
  import cal_div_pkg::*;
#(
  parameter int WIN_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEn,
  input  logic             tick,
  input  logic             calSign,
  input  logic [CAL_W-1:0] calMag,
  output stepCtl_t         stepCtl
);
  logic [WIN_BITS-1:0] secCount;
  logic [CAL_W-1:0]    pending;
  logic                windowEnd;

  assign windowEnd = tick && (secCount == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCount <= '0;
      pending  <= '0;
    end else begin
      if (tick) secCount <= secCount + 1'b1;
      if (windowEnd) pending <= calMag;
      else if (oscEn && (pending != '0)) pending <= pending - 1'b1;
    end
  end

  always_comb begin
    stepCtl.hold = oscEn && (pending != '0) && !calSign;
    stepCtl.dbl  = oscEn && (pending != '0) &&  calSign;
  end

  // R6: magnitude captured at the window boundary
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    windowEnd |=> pending == $past(calMag));

  // R7 / R8: one adjustment consumed per enable while trim remains
  assert_consume_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn && pending != '0 && !windowEnd) |=> pending == $past(pending) - 1'b1);

  // R3: idle cycles leave the trim state untouched
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !tick) |=> ($stable(pending) && $stable(secCount)));
endmodule

// File: rtl/cal_div_data.sv
module cal_div_data
  import cal_div_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int TAP_BIT  = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscEn,
  input  stepCtl_t stepCtl,
  output logic     tick,
  output logic     sq
);
  localparam logic [DIV_BITS-1:0] STEP_ONE = DIV_BITS'(1);
  localparam logic [DIV_BITS-1:0] STEP_TWO = DIV_BITS'(2);

  logic [DIV_BITS-1:0] count;
  logic                advance;

  assign advance = oscEn && !stepCtl.hold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      if (advance) count <= count + (stepCtl.dbl ? STEP_TWO : STEP_ONE);
      tick <= advance && !stepCtl.dbl && (count == '1);
    end
  end

  assign sq = count[TAP_BIT];

  // R2: tick lasts one clock
  assert_tick_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R7: swallowed pulse holds the position
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepCtl.hold |=> count == $past(count));

  // R8: doubled pulse never crosses the wrap point
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    stepCtl.dbl |=> count == $past(count) + STEP_TWO);
endmodule

// File: rtl/cal_divider.sv
module cal_divider
  import cal_div_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int TAP_BIT  = 5,
  parameter int WIN_BITS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic [7:0] ctrlByte,
  output logic       tickOut,
  output logic       sqOut,
  output logic       pinOut
);
  stepCtl_t stepCtl;
  logic     pinLevel, toneSel;

  assign pinLevel = ctrlByte[7];
  assign toneSel  = ctrlByte[6];

  cal_div_ctrl #(.WIN_BITS(WIN_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .tick(tickOut),
    .calSign(ctrlByte[5]), .calMag(ctrlByte[CAL_W-1:0]), .stepCtl(stepCtl)
  );

  cal_div_data #(.DIV_BITS(DIV_BITS), .TAP_BIT(TAP_BIT)) data_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stepCtl(stepCtl),
    .tick(tickOut), .sq(sqOut)
  );

  assign pinOut = toneSel ? sqOut : pinLevel;

  // R1: reset quiets the tick
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> !tickOut);

  // R3: tick only follows an oscillator pulse
  assert_tick_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickOut) |-> $past(oscEn));
endmodule

// File: tb/cal_divider_tb_top.sv
module cal_divider_tb_top;
  localparam int DIV_BITS = 8;
  localparam int TAP_BIT  = 2;
  localparam int WIN_BITS = 2;
  localparam int SEC = 1 << DIV_BITS;
  localparam int WIN = 1 << WIN_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b0;
  logic [7:0] ctrlByte = 8'h00;
  logic tickOut, sqOut, pinOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cal_divider #(.DIV_BITS(DIV_BITS), .TAP_BIT(TAP_BIT), .WIN_BITS(WIN_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .ctrlByte(ctrlByte),
    .tickOut(tickOut), .sqOut(sqOut), .pinOut(pinOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic runCase(input logic sgn, input int cal);
    int enTotal = 0;
    int last = 0;
    int n = 0;
    int expLen;
    int expSq;
    logic prevTick = 1'b0;
    ctrlByte = {1'b0, 1'b1, sgn, 5'(cal)};
    rstN = 1'b0;
    oscEn = 1'b0;
    repeat (3) @(negedge clk);
    check(tickOut == 1'b0, "R1 tick in reset", int'(tickOut), 0);
    check(sqOut == 1'b0, "R1 square in reset", int'(sqOut), 0);
    rstN = 1'b1;
    oscEn = 1'b1;
    while (n < 10) begin
      @(negedge clk);
      if (oscEn) enTotal++;
      if (n < WIN) begin
        expSq = ((enTotal % SEC) >> TAP_BIT) & 1;
        check(int'(sqOut) == expSq, "R4 square position", int'(sqOut), expSq);
        check(pinOut == sqOut, "R5 pin follows tone", int'(pinOut), int'(sqOut));
      end
      if (tickOut) begin
        check(!prevTick, "R2 tick width", 1, 0);
        n++;
        expLen = SEC;
        if (n > 1 && ((n - 1) % WIN) == 0)
          expLen = sgn ? SEC - cal : SEC + cal;
        if (n <= WIN)
          check(enTotal - last == expLen, "R1 first window exact", enTotal - last, expLen);
        else if (cal == 0)
          check(enTotal - last == expLen, "R9 zero trim exact", enTotal - last, expLen);
        else if (expLen == SEC)
          check(enTotal - last == expLen, "R6 plain second in window", enTotal - last, expLen);
        else if (sgn)
          check(enTotal - last == expLen, "R8 faster second", enTotal - last, expLen);
        else
          check(enTotal - last == expLen, "R7 slower second", enTotal - last, expLen);
        last = enTotal;
      end
      prevTick = tickOut;
      oscEn = ~oscEn;   // R3: enable every other clock
    end
    oscEn = 1'b0;
  endtask

  initial begin
    int cals[7] = '{0, 1, 2, 7, 16, 30, 31};
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 7; k++)
        runCase(s[0], cals[k]);

    // R5: static level on the pin
    for (int lvl = 0; lvl < 2; lvl++) begin
      ctrlByte = {lvl[0], 1'b0, 6'h00};
      oscEn = 1'b1;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        check(int'(pinOut) == lvl, "R5 static level", int'(pinOut), lvl);
        oscEn = ~oscEn;
      end
    end
    // R3: no enables means no tick and a frozen square wave
    oscEn = 1'b0;
    ctrlByte = 8'h40;
    @(negedge clk);
    begin
      logic held;
      held = sqOut;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        if (c % 100 == 0) begin
          check(tickOut == 1'b0, "R3 idle tick", int'(tickOut), 0);
          check(sqOut == held, "R3 idle square", int'(sqOut), int'(held));
        end
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule